// File: doc/BRIEF.md
# Single-Wire Bus Device Responder

This block is the device end of a single-wire, open-drain, half-duplex bus. It is meant as synthesizable bus-functional logic that answers a bus master. It watches the shared wire and times every low period from its falling edge. If the master holds the wire low for the reset threshold, the block treats it as a bus reset. After the master releases the wire, the block waits a short delay and then pulls the wire low for a fixed time as its presence reply.

Every shorter low period is a data slot that the master starts. If no transmit byte is pending, the slot is a write slot. The block samples the wire at a fixed point after the falling edge and shifts the bit into a receive byte, least significant bit first. If a transmit byte is pending, the slot is a read slot. The block sends the next bit, least significant bit first. It sends a 0 by holding the wire low past the master's sampling point and sends a 1 by leaving the wire alone.

Received bytes leave the block on a valid/ready stream. The bus cannot be stalled, so back-pressure cannot hold off the master. A byte that is not taken stays on `rx_data` with `rx_valid` held high. If another byte completes first, it replaces the held byte. Transmit bytes enter on a valid/ready stream. `tx_ready` is high only while no transmit byte is pending, and it returns high once all bits of the byte have been sent.

Top module: `owr_responder`

## Requirements
- R1: After reset the wire is released (`ow_drive_low` = 0), `rx_valid` = 0 and `tx_ready` = 1.
- R2: A low period of at least RST_MIN_US microseconds that then ends is a bus reset. About PRES_WAIT_US after the wire rises, the block drives the wire low for PRES_LOW_US as its presence reply. With the default values that is a 30 us wait and a 120 us low, and both lie inside the 15–60 us and 60–240 us windows.
- R3: In a write slot the wire is sampled SAMPLE_US after the falling edge is detected. Low gives a 0 bit and high gives a 1 bit. If the wire rises before the sample point, the bit is a 1.
- R4: Write bits are shifted in least significant bit first. When the DATA_W-th bit is complete, the byte appears on `rx_data` with `rx_valid` = 1.
- R5: `rx_valid` stays high, with `rx_data` unchanged, until a cycle with `rx_ready` = 1. If a new byte completes while the old one is still held, the new byte replaces it.
- R6: A transmit byte is taken in a cycle where `tx_valid` and `tx_ready` are both 1. `tx_ready` then stays 0 while the byte is pending. Every slot that starts while a byte is pending is a read slot.
- R7: In a read slot the next bit is sent least significant bit first. For a 0 the wire is driven low from the detected falling edge for HOLD0_US and then released. For a 1 the wire is not driven. After DATA_W read slots, `tx_ready` returns to 1.
- R8: A bus reset throws away any partly received byte and any pending transmit byte.
- R9: A low period shorter than RST_MIN_US gives no presence reply.
- R10: Outside the presence reply, the wire is driven only inside a slot that the master's falling edge has started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ow_in | input | 1 | Sensed level of the shared wire |
| ow_drive_low | output | 1 | Open-drain enable: 1 pulls the wire low |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | DATA_W | Received byte |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_ready | output | 1 | No transmit byte pending; offer is accepted |
| tx_data | input | DATA_W | Byte to transmit |

## Verification
The hardest case to reach from the ports is a bus reset that arrives while a byte is partly done in either direction. The stimulus writes a few bits, or loads a transmit byte and reads only some of its bits. It then holds the wire low past the reset threshold and afterwards sends a complete byte. A correct abort shows up two ways: the new byte arrives intact, and it is taken as writes rather than reads. The bench models the wire as a wired-AND of the master and the device, so every drive decision is seen on the wire itself.

// File: rtl/owr_pkg.sv
`timescale 1ns/1ps
package owr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SLOT   = 3'd1,
    ST_PWAIT  = 3'd2,
    ST_PDRIVE = 3'd3,
    ST_PEND   = 3'd4
  } owr_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/owr_tick_gen.sv
`timescale 1ns/1ps
module owr_tick_gen #(
  parameter int TICKS_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam logic [CW-1:0] LIM = CW'(TICKS_PER_US - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/owr_line_sync.sv
`timescale 1ns/1ps
module owr_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ow_in,
  output logic level,
  output logic fell,
  output logic rose
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= ow_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level = s2;
  assign fell  = s3 & ~s2;
  assign rose  = ~s3 & s2;
endmodule

// File: rtl/owr_bit_engine.sv
`timescale 1ns/1ps
module owr_bit_engine
  import owr_pkg::*;
#(
  parameter int RST_MIN_US   = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LOW_US  = 120,
  parameter int SAMPLE_US    = 30,
  parameter int HOLD0_US     = 45
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       level,
  input  logic       fell,
  input  logic       rose,
  input  logic       tx_active,
  input  logic       tx_bit,
  output logic       drive_low,
  output logic       rx_bit_stb,
  output logic       rx_bit,
  output logic       tx_bit_stb,
  output logic       reset_stb,
  output owr_state_e state
);
  localparam int TMAX = max3(RST_MIN_US, PRES_LOW_US, max3(PRES_WAIT_US, SAMPLE_US, HOLD0_US));
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_SAT   = TW'(TMAX);
  localparam logic [TW-1:0] T_RST   = TW'(RST_MIN_US);
  localparam logic [TW-1:0] T_SMP   = TW'(SAMPLE_US);
  localparam logic [TW-1:0] T_HOLD  = TW'(HOLD0_US);
  localparam logic [TW-1:0] T_PWAIT = TW'(PRES_WAIT_US - 1);
  localparam logic [TW-1:0] T_PLOW  = TW'(PRES_LOW_US - 1);

  logic [TW-1:0] t;
  logic          is_read;
  logic          cur_bit;
  logic          smp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      t          <= '0;
      is_read    <= 1'b0;
      cur_bit    <= 1'b1;
      smp        <= 1'b1;
      rx_bit     <= 1'b0;
      rx_bit_stb <= 1'b0;
      tx_bit_stb <= 1'b0;
      reset_stb  <= 1'b0;
    end else begin
      rx_bit_stb <= 1'b0;
      tx_bit_stb <= 1'b0;
      reset_stb  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fell) begin
            state   <= ST_SLOT;
            t       <= '0;
            is_read <= tx_active;
            cur_bit <= tx_bit;
            smp     <= 1'b1;
          end
        end
        ST_SLOT: begin
          if (rose) begin
            t <= '0;
            if (t >= T_RST) begin
              reset_stb <= 1'b1;
              state     <= ST_PWAIT;
            end else begin
              state <= ST_IDLE;
              if (is_read) begin
                tx_bit_stb <= 1'b1;
              end else begin
                rx_bit_stb <= 1'b1;
                rx_bit     <= smp;
              end
            end
          end else if (tick) begin
            if (t != T_SAT) t <= t + 1'b1;
            if (t == T_SMP) smp <= level;
          end
        end
        ST_PWAIT: begin
          if (tick) begin
            if (t == T_PWAIT) begin
              state <= ST_PDRIVE;
              t     <= '0;
            end else begin
              t <= t + 1'b1;
            end
          end
        end
        ST_PDRIVE: begin
          if (tick) begin
            if (t == T_PLOW) begin
              state <= ST_PEND;
              t     <= '0;
            end else begin
              t <= t + 1'b1;
            end
          end
        end
        ST_PEND: begin
          if (level) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign drive_low = (state == ST_PDRIVE) ||
                     ((state == ST_SLOT) && is_read && !cur_bit && (t < T_HOLD));
endmodule

// File: rtl/owr_byte_shifter.sv
`timescale 1ns/1ps
module owr_byte_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit_stb,
  input  logic              rx_bit,
  input  logic              tx_bit_stb,
  input  logic              reset_stb,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_active,
  output logic              tx_bit
);
  localparam int CNTW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(DATA_W - 1);

  logic [DATA_W-1:0] rx_sr, tx_sr;
  logic [CNTW-1:0]   rx_cnt, tx_cnt;
  logic [DATA_W-1:0] rx_next;
  logic              tx_pending;

  assign rx_next   = {rx_bit, rx_sr[DATA_W-1:1]};
  assign tx_ready  = !tx_pending;
  assign tx_active = tx_pending;
  assign tx_bit    = tx_sr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sr    <= '0;
      rx_cnt   <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (reset_stb) begin
        rx_cnt <= '0;
      end else if (rx_bit_stb) begin
        rx_sr  <= rx_next;
        rx_cnt <= (rx_cnt == LAST) ? '0 : rx_cnt + 1'b1;
      end
      if (rx_bit_stb && !reset_stb && rx_cnt == LAST) begin
        rx_valid <= 1'b1;
        rx_data  <= rx_next;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sr      <= '0;
      tx_cnt     <= '0;
      tx_pending <= 1'b0;
    end else begin
      if (reset_stb) begin
        tx_pending <= 1'b0;
      end else if (tx_bit_stb) begin
        tx_sr  <= tx_sr >> 1;
        tx_cnt <= tx_cnt + 1'b1;
        if (tx_cnt == LAST) tx_pending <= 1'b0;
      end
      if (tx_valid && !tx_pending) begin
        tx_sr      <= tx_data;
        tx_cnt     <= '0;
        tx_pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/owr_responder.sv
`timescale 1ns/1ps
module owr_responder
  import owr_pkg::*;
#(
  parameter int TICKS_PER_US = 50,
  parameter int DATA_W       = 8,
  parameter int RST_MIN_US   = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LOW_US  = 120,
  parameter int SAMPLE_US    = 30,
  parameter int HOLD0_US     = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ow_in,
  output logic              ow_drive_low,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data
);
  logic       tick, level, fell, rose;
  logic       tx_active, tx_bit;
  logic       rx_bit_stb, rx_bit, tx_bit_stb, reset_stb;
  owr_state_e eng_state;

  owr_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ow_in(ow_in),
    .level(level), .fell(fell), .rose(rose)
  );

  owr_tick_gen #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(fell | rose), .tick(tick)
  );

  owr_bit_engine #(
    .RST_MIN_US(RST_MIN_US), .PRES_WAIT_US(PRES_WAIT_US),
    .PRES_LOW_US(PRES_LOW_US), .SAMPLE_US(SAMPLE_US), .HOLD0_US(HOLD0_US)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level(level), .fell(fell),
    .rose(rose), .tx_active(tx_active), .tx_bit(tx_bit),
    .drive_low(ow_drive_low), .rx_bit_stb(rx_bit_stb), .rx_bit(rx_bit),
    .tx_bit_stb(tx_bit_stb), .reset_stb(reset_stb), .state(eng_state)
  );

  owr_byte_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .rx_bit_stb(rx_bit_stb), .rx_bit(rx_bit),
    .tx_bit_stb(tx_bit_stb), .reset_stb(reset_stb),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_active(tx_active), .tx_bit(tx_bit)
  );
endmodule

// File: rtl/owr_responder_chk.sv
`timescale 1ns/1ps
module owr_responder_chk
  import owr_pkg::*;
#(
  parameter int TICKS_PER_US = 50,
  parameter int PRES_LOW_US  = 120,
  parameter int HOLD0_US     = 45
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ow_drive_low,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       fell,
  input logic       rx_bit_stb,
  input logic       reset_stb,
  input owr_state_e state
);
  localparam int LONGEST = ((PRES_LOW_US > HOLD0_US) ? PRES_LOW_US : HOLD0_US) + 2;
  localparam int DRIVE_MAX = LONGEST * TICKS_PER_US + 4;
  localparam int DW = $clog2(DRIVE_MAX + 2);

  logic [DW-1:0] drive_run;

  always_ff @(posedge clk) begin
    if (!rst_n) drive_run <= '0;
    else if (!ow_drive_low) drive_run <= '0;
    else if (drive_run != {DW{1'b1}}) drive_run <= drive_run + 1'b1;
  end

  // R2
  drive_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_run <= DW'(DRIVE_MAX));

  // R4
  rx_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(rx_bit_stb));

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R6
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_stb && !tx_valid) |=> tx_ready);

  // R10
  slot_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ow_drive_low) && state == ST_SLOT) |-> $past(fell));
endmodule

bind owr_responder owr_responder_chk #(
  .TICKS_PER_US(TICKS_PER_US), .PRES_LOW_US(PRES_LOW_US), .HOLD0_US(HOLD0_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ow_drive_low(ow_drive_low),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .fell(fell), .rx_bit_stb(rx_bit_stb),
  .reset_stb(reset_stb), .state(eng_state)
);

// File: tb/owr_responder_test.sv
`timescale 1ns/1ps
module owr_responder_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         m_low = 1'b0;
  logic         rx_ready = 1'b0;
  logic         tx_valid = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         ow_drive_low, rx_valid, tx_ready;
  logic [W-1:0] rx_data;
  wire          line = ~(m_low | ow_drive_low);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  owr_responder #(
    .TICKS_PER_US(1), .DATA_W(W), .RST_MIN_US(480), .PRES_WAIT_US(30),
    .PRES_LOW_US(120), .SAMPLE_US(30), .HOLD0_US(45)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ow_in(line), .ow_drive_low(ow_drive_low),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic master_reset(input string req);
    m_low = 1'b1;
    cyc(600);
    m_low = 1'b0;
    cyc(20);  chk({req, " presence wait"}, 32'(line), 32'd1);
    cyc(30);  chk({req, " presence low early"}, 32'(line), 32'd0);
    cyc(90);  chk({req, " presence low late"}, 32'(line), 32'd0);
    cyc(40);  chk({req, " presence released"}, 32'(line), 32'd1);
  endtask

  task automatic write_bit(input logic b);
    m_low = 1'b1;
    if (b) begin
      cyc(5);
      m_low = 1'b0;
      cyc(10);
      chk("R10 no drive in write slot", 32'(line), 32'd1);
      cyc(65);
    end else begin
      cyc(70);
      m_low = 1'b0;
      cyc(10);
    end
  endtask

  task automatic write_byte(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) write_bit(v[i]);
  endtask

  task automatic read_bit(output logic b);
    m_low = 1'b1;
    cyc(4);
    m_low = 1'b0;
    cyc(11);
    b = line;
    cyc(45);
    chk("R7 wire released late in read slot", 32'(line), 32'd1);
    cyc(20);
  endtask

  task automatic read_byte(output logic [W-1:0] v);
    logic b;
    for (int i = 0; i < W; i++) begin
      read_bit(b);
      v[i] = b;
    end
  endtask

  task automatic load_tx(input logic [W-1:0] v);
    tx_data  = v;
    tx_valid = 1'b1;
    cyc(1);
    tx_valid = 1'b0;
    chk("R6 tx_ready low while pending", 32'(tx_ready), 32'd0);
  endtask

  task automatic accept_rx();
    rx_ready = 1'b1;
    cyc(1);
    rx_ready = 1'b0;
    chk("R5 rx_valid cleared on ready", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_reset_state();
    chk("R1 wire released", 32'(ow_drive_low), 32'd0);
    chk("R1 rx_valid low", 32'(rx_valid), 32'd0);
    chk("R1 tx_ready high", 32'(tx_ready), 32'd1);
  endtask

  task automatic t_presence();
    master_reset("R2");
  endtask

  task automatic t_write_bytes();
    write_byte(8'hA5);
    chk("R4 rx_valid after byte", 32'(rx_valid), 32'd1);
    chk("R3 R4 byte A5 lsb first", 32'(rx_data), 32'hA5);
    accept_rx();
    write_byte(8'h3C);
    chk("R3 R4 byte 3C", 32'(rx_data), 32'h3C);
    accept_rx();
  endtask

  task automatic t_backpressure();
    write_byte(8'h11);
    cyc(30);
    chk("R5 held while not ready", 32'(rx_valid), 32'd1);
    chk("R5 held data", 32'(rx_data), 32'h11);
    write_byte(8'h80);
    chk("R5 overwrite valid", 32'(rx_valid), 32'd1);
    chk("R5 overwrite data", 32'(rx_data), 32'h80);
    accept_rx();
  endtask

  task automatic t_read();
    logic [W-1:0] got;
    load_tx(8'h6B);
    read_byte(got);
    chk("R7 read byte 6B lsb first", 32'(got), 32'h6B);
    chk("R7 tx_ready after byte", 32'(tx_ready), 32'd1);
    chk("R6 reads leave rx idle", 32'(rx_valid), 32'd0);
    load_tx(8'h00);
    read_byte(got);
    chk("R7 read byte 00", 32'(got), 32'h00);
  endtask

  task automatic t_short_low();
    m_low = 1'b1;
    cyc(200);
    m_low = 1'b0;
    cyc(50);
    chk("R9 no presence early", 32'(line), 32'd1);
    cyc(90);
    chk("R9 no presence late", 32'(line), 32'd1);
  endtask

  task automatic t_abort();
    logic b;
    for (int i = 0; i < 4; i++) write_bit(1'b1);
    master_reset("R8 rx abort");
    write_byte(8'h5A);
    chk("R8 byte after rx abort", 32'(rx_data), 32'h5A);
    accept_rx();
    load_tx(8'hFF);
    for (int i = 0; i < 3; i++) read_bit(b);
    master_reset("R8 tx abort");
    chk("R8 pending tx dropped", 32'(tx_ready), 32'd1);
    write_byte(8'hC3);
    chk("R8 slots are writes after abort", 32'(rx_data), 32'hC3);
    chk("R8 rx_valid after abort byte", 32'(rx_valid), 32'd1);
    accept_rx();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    t_reset_state();
    t_presence();
    t_write_bytes();
    t_backpressure();
    t_read();
    t_short_low();
    t_abort();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule